// File: doc/BRIEF.md
# Fixed-Latency Pipelined Bus Memory

This block is a word-addressed memory sitting as a slave on a pipelined Wishbone bus with a 32-bit data path split into four byte lanes. It never stalls. Every cycle in which the master holds both `i_cyc` and `i_stb` high is a request, accepted on that very cycle. Writes take effect at once, and only the byte lanes the select bits enable are changed.

The acknowledge for each request comes back a fixed number of clock cycles later, set by the `LATENCY` parameter. The block captures the response data when it takes the request, so a read returns the word as it stood then and a write returns the merged value it just stored. Acknowledge and data travel together through a circular delay buffer. Several requests can therefore be in flight at once and they retire in issue order.

Dropping `i_cyc` cancels every pending acknowledge. Reset does the same. Neither one touches the memory contents. The number of words is `WORDS` rounded up to a power of two, and address bits above that depth are ignored, so addresses beyond it wrap.

Top module: `pipe_mem_slave`

## Requirements
- R1: `o_stall` is low on every cycle, including reset, and every cycle with `i_cyc` and `i_stb` high is taken as a request.
- R2: Each request made with `i_cyc` high produces exactly one `o_ack` pulse, exactly `LATENCY` cycles after the request cycle, provided `i_cyc` stays high and reset stays inactive in between.
- R3: Select bit n (n = 0..3) governs data bits 8n+7 down to 8n: bit 3 covers 31:24, bit 2 covers 23:16, bit 1 covers 15:8 and bit 0 covers 7:0.
- R4: A write replaces only the enabled byte lanes of the addressed word. Disabled lanes keep their previous value.
- R5: The memory holds WORDS rounded up to a power of two words (256 for WORDS = 200). Only the low log2(depth) address bits select a word, so address 0x105 reaches word 0x05.
- R6: `o_rdata` during an acknowledge equals the addressed word as it stood just after that request. For a read this is the stored word; for a write it is the merged new value.
- R7: On every cycle with `o_ack` low, `o_rdata` is zero.
- R8: A clock edge at which `i_cyc` is low cancels every pending acknowledge. None of them appears later, and memory contents are kept.
- R9: While `rst_n` is sampled low, `o_ack` and `o_rdata` are zero on the following cycle and pending acknowledges are dropped. Memory contents survive reset.
- R10: Requests on consecutive cycles give acknowledges on consecutive cycles, in the order the requests were issued.
- R11: With `LATENCY` = 1, the acknowledge appears on the cycle right after the request.
- R12: A cycle with `i_cyc` high and `i_stb` low is not a request. It produces no acknowledge and does not write memory, even when `i_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| i_cyc | input | 1 | Bus cycle active; low flushes pending acknowledges |
| i_stb | input | 1 | Request strobe |
| i_we | input | 1 | 1 = write, 0 = read |
| i_addr | input | ADDR_W | Word address (low bits used, upper bits wrap) |
| i_wdata | input | DATA_W | Write data |
| i_sel | input | DATA_W/8 | Byte-lane enables |
| o_ack | output | 1 | Acknowledge, LATENCY cycles after a request |
| o_stall | output | 1 | Always low |
| o_rdata | output | DATA_W | Response data, zero when no acknowledge |

## Verification
The assertions take it for granted that the master drives `i_cyc`, `i_stb` and `i_we` to known levels on every clock edge after reset. The in-flight bound also relies on the master not counting on acknowledges from a bus cycle it has already ended. The stimulus is driven only between clock edges and changes inputs only on falling edges. It drops `i_cyc` or pulses reset only as a deliberate cancellation step. It reads only addresses it has already written, so the unset memory contents never reach a compared value.

// File: rtl/pms_pkg.sv
// Package: shared constants and helpers for the pipelined memory slave.
// Assumes callers pass positive sizes to ceil_pow2.
package pms_pkg;

    localparam int LANE_W = 8;

    // Smallest power of two that is not below n.
    function automatic int ceil_pow2(input int n);
        int p;
        p = 1;
        while (p < n) p = p * 2;
        return p;
    endfunction

endpackage

// File: rtl/pms_lane_merge.sv
// Module: pms_lane_merge
// Builds the word a request leaves behind. On a write, each enabled byte
// lane takes the write data and the other lanes keep the old word. On a
// read, the old word passes through unchanged.
// Assumes DATA_W is a multiple of the lane width.
module pms_lane_merge
    import pms_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              we,
    input  logic [LANES-1:0]  sel,
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] new_word
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Pick write data or old data for one byte lane.
        always_comb begin
            if (we && sel[g])
                new_word[g*LANE_W +: LANE_W] = wdata[g*LANE_W +: LANE_W];
            else
                new_word[g*LANE_W +: LANE_W] = old_word[g*LANE_W +: LANE_W];
        end

        // A lane that is not selected keeps its old value.
        always_comb begin
            if (!(we && sel[g]))
                AST_LANE_KEEP: assert (new_word[g*LANE_W +: LANE_W] == old_word[g*LANE_W +: LANE_W]); // R4
        end
    end

endmodule

// File: rtl/pms_word_store.sv
// Module: pms_word_store
// Word array with a combinational read port and a synchronous write port
// on the same address. It has no reset on purpose, so the contents
// survive reset and bus cancellation.
// Assumes DEPTH_LOG >= 1.
module pms_word_store #(
    parameter int DATA_W    = 32,
    parameter int DEPTH_LOG = 8,
    localparam int DEPTH    = 1 << DEPTH_LOG
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [DEPTH_LOG-1:0] idx,
    input  logic [DATA_W-1:0]    wr_word,
    output logic [DATA_W-1:0]    rd_word
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Read the addressed word before this cycle's write.
    assign rd_word = mem[idx];

    // Store the merged word when the request is a write.
    always_ff @(posedge clk) begin
        if (wr_en) mem[idx] <= wr_word;
    end

endmodule

// File: rtl/pms_latency_line.sv
// Module: pms_latency_line
// Carries each request's acknowledge and captured data through a circular
// buffer whose length is LATENCY rounded up to a power of two, then
// presents it from a register LATENCY cycles after entry. The buffer is
// flushed by reset or by flush (bus cycle dropped).
// Assumes LATENCY >= 1. Empty slots hold valid = 0 and data = 0.
module pms_latency_line
    import pms_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int LATENCY = 3,
    localparam int BUF_LEN = ceil_pow2(LATENCY),
    localparam int PTR_W   = (BUF_LEN > 1) ? $clog2(BUF_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_ack,
    output logic [DATA_W-1:0] out_data
);

    if (LATENCY == 1) begin : g_direct
        // A single register stage: the response appears on the next cycle.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                out_ack  <= 1'b0;
                out_data <= '0;
            end else begin
                out_ack  <= in_vld;
                out_data <= in_vld ? in_data : '0;
            end
        end
    end else begin : g_ring
        logic [BUF_LEN-1:0] slot_vld;
        logic [DATA_W-1:0]  slot_dat [BUF_LEN];
        logic [PTR_W-1:0]   wr_ptr;
        logic [PTR_W-1:0]   rd_ptr;

        // Read the slot written LATENCY-1 edges ago.
        assign rd_ptr = wr_ptr - PTR_W'(LATENCY - 1);

        // Advance the write pointer on every cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) wr_ptr <= '0;
            else        wr_ptr <= wr_ptr + 1'b1;
        end

        // Fill one slot, emit the oldest one, or clear everything on flush.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                slot_vld <= '0;
                for (int i = 0; i < BUF_LEN; i++) slot_dat[i] <= '0;
                out_ack  <= 1'b0;
                out_data <= '0;
            end else begin
                slot_vld[wr_ptr] <= in_vld;
                slot_dat[wr_ptr] <= in_vld ? in_data : '0;
                out_ack  <= slot_vld[rd_ptr];
                out_data <= slot_dat[rd_ptr];
            end
        end
    end

    AST_FLUSH_SILENCES: assert property (@(posedge clk) disable iff (!rst_n) flush |=> !out_ack); // R8
    AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !out_ack |-> out_data == '0); // R7
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!out_ack && out_data == '0)); // R9

endmodule

// File: rtl/pipe_mem_slave.sv
// Module: pipe_mem_slave
// Pipelined bus memory slave that never stalls. Every cycle with cyc and
// stb high is taken as a request, the write merges at once, and the
// response (acknowledge plus the word after the request) returns LATENCY
// cycles later. Dropping cyc or asserting reset cancels pending responses.
// Assumes LATENCY >= 1, WORDS >= 2 and ADDR_W >= log2 of the rounded depth.
module pipe_mem_slave
    import pms_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int WORDS   = 200,
    parameter int LATENCY = 3,
    localparam int LANES     = DATA_W / LANE_W,
    localparam int DEPTH     = ceil_pow2(WORDS),
    localparam int DEPTH_LOG = $clog2(DEPTH),
    localparam int CNT_W     = $clog2(LATENCY + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_cyc,
    input  logic              i_stb,
    input  logic              i_we,
    input  logic [ADDR_W-1:0] i_addr,
    input  logic [DATA_W-1:0] i_wdata,
    input  logic [LANES-1:0]  i_sel,
    output logic              o_ack,
    output logic              o_stall,
    output logic [DATA_W-1:0] o_rdata
);

    logic                 req;
    logic [DEPTH_LOG-1:0] word_idx;
    logic [DATA_W-1:0]    old_word;
    logic [DATA_W-1:0]    new_word;

    // Accept a request whenever the strobe is up inside a bus cycle.
    assign req      = i_cyc && i_stb;
    assign word_idx = i_addr[DEPTH_LOG-1:0];
    assign o_stall  = 1'b0;

    pms_word_store #(
        .DATA_W    (DATA_W),
        .DEPTH_LOG (DEPTH_LOG)
    ) u_store (
        .clk     (clk),
        .wr_en   (req && i_we),
        .idx     (word_idx),
        .wr_word (new_word),
        .rd_word (old_word)
    );

    pms_lane_merge #(
        .DATA_W (DATA_W)
    ) u_merge (
        .we       (i_we),
        .sel      (i_sel),
        .old_word (old_word),
        .wdata    (i_wdata),
        .new_word (new_word)
    );

    pms_latency_line #(
        .DATA_W  (DATA_W),
        .LATENCY (LATENCY)
    ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (!i_cyc),
        .in_vld   (req),
        .in_data  (new_word),
        .out_ack  (o_ack),
        .out_data (o_rdata)
    );

    // Checker state: requests taken but not yet acknowledged.
    logic [CNT_W-1:0] inflight;

    // Count requests in and acknowledges out; cancellation empties the count.
    always_ff @(posedge clk) begin
        if (!rst_n || !i_cyc)
            inflight <= '0;
        else
            inflight <= inflight + CNT_W'(req) - CNT_W'(o_ack);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) inflight <= CNT_W'(LATENCY)); // R2
    AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n) o_ack |-> inflight != '0); // R2
    AST_NEVER_STALL: assert property (@(posedge clk) disable iff (!rst_n) req |-> !o_stall); // R1

    if (LATENCY == 1) begin : g_lat1_chk
        AST_NEXT_CYCLE_ACK: assert property (@(posedge clk) disable iff (!rst_n) req |=> o_ack); // R11
    end

endmodule

// File: tb/pipe_mem_slave_bench.sv
module pipe_mem_slave_bench;

    localparam int LAT = 3;
    localparam int NV  = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  sel = '0;
    logic        ack, stall, ack1, stall1;
    logic [31:0] rdata, rdata1;

    always #10 clk = ~clk;  // 50 MHz

    pipe_mem_slave #(.ADDR_W(16), .DATA_W(32), .WORDS(200), .LATENCY(LAT)) u_pipe_mem_slave (
        .clk(clk), .rst_n(rst_n), .i_cyc(cyc), .i_stb(stb), .i_we(we), .i_addr(addr),
        .i_wdata(wdata), .i_sel(sel), .o_ack(ack), .o_stall(stall), .o_rdata(rdata));

    pipe_mem_slave #(.ADDR_W(16), .DATA_W(32), .WORDS(200), .LATENCY(1)) u_lat1 (
        .clk(clk), .rst_n(rst_n), .i_cyc(cyc), .i_stb(stb), .i_we(we), .i_addr(addr),
        .i_wdata(wdata), .i_sel(sel), .o_ack(ack1), .o_stall(stall1), .o_rdata(rdata1));

    int n_chk = 0, n_bad = 0, t = 0;
    logic [31:0] model [256];
    logic        exp_ack  [16];
    logic [31:0] exp_dat  [16];
    int          exp_tag  [16];
    logic        exp1     [16];
    string       cur_tag = "R9";

    // Vector: tag[58:55] cyc stb we sel[3:0] addr[15:0] data[31:0]
    function automatic logic [58:0] mk(input int tag, input logic c, input logic s,
                                       input logic w, input logic [3:0] sl,
                                       input logic [15:0] a, input logic [31:0] d);
        return {4'(tag), c, s, w, sl, a, d};
    endfunction

    localparam logic [58:0] VEC [NV] = '{
        mk(6, 1, 1, 1, 4'hF, 16'h0005, 32'h11223344),  // R6 write returns new word
        mk(6, 1, 1, 1, 4'hF, 16'h0006, 32'hAABBCCDD),
        mk(6, 1, 1, 0, 4'hF, 16'h0005, 32'h0),         // R6 read
        mk(3, 1, 1, 1, 4'h1, 16'h0005, 32'hFFFFFF99),  // R3 lane 0 only
        mk(3, 1, 1, 1, 4'h8, 16'h0005, 32'h77FFFFFF),  // R3 lane 3 only
        mk(5, 1, 1, 0, 4'h0, 16'h0105, 32'h0),         // R5 wrap to word 5
        mk(12, 1, 0, 1, 4'hF, 16'h0006, 32'h0),        // R12 strobe low, no write
        mk(12, 1, 1, 0, 4'hF, 16'h0006, 32'h0),        // R12 word 6 unchanged
        mk(4, 1, 1, 1, 4'h6, 16'h0006, 32'h00EEFF00),  // R4 middle lanes
        mk(5, 1, 1, 1, 4'hF, 16'h01FF, 32'hCAFE0001),  // R5 write via high bits
        mk(5, 1, 1, 0, 4'hF, 16'h00FF, 32'h0),         // R5 read word 0xFF
        mk(1, 1, 0, 0, 4'h0, 16'h0000, 32'h0),         // R1 idle
        mk(10, 1, 1, 0, 4'h0, 16'h0005, 32'h0),        // R10 back-to-back reads
        mk(10, 1, 1, 0, 4'h0, 16'h0006, 32'h0),
        mk(10, 1, 1, 0, 4'h0, 16'h00FF, 32'h0),
        mk(10, 1, 1, 1, 4'h2, 16'h0005, 32'h0000BB00),
        mk(2, 1, 0, 0, 4'h0, 16'h0000, 32'h0),         // R2 drain
        mk(2, 1, 0, 0, 4'h0, 16'h0000, 32'h0)
    };

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // One bus cycle: check this cycle's outputs, then drive the next inputs.
    task automatic step(input logic rst, input logic c, input logic s, input logic w,
                        input logic [3:0] sl, input logic [15:0] a, input logic [31:0] d, input int tag);
        logic [31:0] nw;
        @(negedge clk);
        check("R1", "stall", 32'(stall), 32'h0);
        if (exp_ack[t%16]) begin
            check($sformatf("R%0d", exp_tag[t%16]), "ack", 32'(ack), 32'h1);
            check($sformatf("R%0d", exp_tag[t%16]), "data", rdata, exp_dat[t%16]);
        end else begin
            check(cur_tag, "no ack", 32'(ack), 32'h0);
            check("R7", "idle data", rdata, 32'h0);
        end
        check("R11", "lat1 ack", 32'(ack1), 32'(exp1[t%16]));
        exp_ack[t%16] = 1'b0;
        exp_dat[t%16] = '0;
        exp1[t%16]    = 1'b0;
        if (rst || !c) begin
            for (int k = 1; k <= LAT; k++) begin
                exp_ack[(t+k)%16] = 1'b0;
                exp_dat[(t+k)%16] = '0;
            end
        end else if (s) begin
            nw = model[a[7:0]];
            for (int l = 0; l < 4; l++)
                if (w && sl[l]) nw[l*8 +: 8] = d[l*8 +: 8];
            model[a[7:0]] = nw;
            exp_ack[(t+LAT)%16] = 1'b1;
            exp_dat[(t+LAT)%16] = nw;
            exp_tag[(t+LAT)%16] = tag;
            exp1[(t+1)%16] = 1'b1;
        end
        rst_n = !rst; cyc = c; stb = s; we = w; sel = sl; addr = a; wdata = d;
        t++;
    endtask

    initial begin
        #400_000;
        n_bad++; n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            exp_ack[i] = 1'b0; exp_dat[i] = '0; exp_tag[i] = 2; exp1[i] = 1'b0;
        end
        repeat (2) @(posedge clk);
        step(1, 0, 0, 0, 4'h0, 16'h0, 32'h0, 9);   // R9 reset state
        step(1, 0, 0, 0, 4'h0, 16'h0, 32'h0, 9);
        cur_tag = "R2";
        foreach (VEC[i])
            step(0, VEC[i][54], VEC[i][53], VEC[i][52], VEC[i][51:48],
                 VEC[i][47:32], VEC[i][31:0], int'(VEC[i][58:55]));
        // R8: cyc drop cancels two in-flight reads, memory kept
        cur_tag = "R8";
        step(0, 1, 1, 0, 4'h0, 16'h0005, 32'h0, 8);
        step(0, 1, 1, 0, 4'h0, 16'h0006, 32'h0, 8);
        step(0, 0, 0, 0, 4'h0, 16'h0, 32'h0, 8);
        for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 4'h0, 16'h0, 32'h0, 8);
        step(0, 1, 1, 0, 4'h0, 16'h0005, 32'h0, 8);
        for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 4'h0, 16'h0, 32'h0, 8);
        // R9: reset cancels an in-flight write, memory kept
        cur_tag = "R9";
        step(0, 1, 1, 1, 4'hF, 16'h0007, 32'h5A5A0F0F, 9);
        step(1, 1, 0, 0, 4'h0, 16'h0, 32'h0, 9);
        for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 4'h0, 16'h0, 32'h0, 9);
        step(0, 1, 1, 0, 4'h0, 16'h0007, 32'h0, 9);
        step(0, 1, 1, 0, 4'h0, 16'h0006, 32'h0, 9);
        for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 4'h0, 16'h0, 32'h0, 9);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule